// File: doc/BRIEF.md
# Cache Hit/Miss Rate Monitor

This block sits beside an instruction cache and measures how well it performs. The cache gives it one pulse per access, marking the access as a hit, a miss, or a hit that needed one wait state. Each kind of event has its own saturating counter. While the monitor is frozen, all three counters ignore events. Software starts and freezes the monitor through a small word-wide register port. Software can also load any counter, and the usual value it loads is zero.

Two programmable limits, one for misses and one for hits, each raise a sticky status flag when their counter climbs to the limit. A free-running interval timer, counted in cycles of the monitor clock, raises a third sticky flag each time a programmed number of running cycles has passed. The timer then reloads by itself. A limit of zero or an interval of zero turns the matching flag off. Software clears each flag by writing a one to its status bit. A level interrupt is raised when any flag is set and interrupts are enabled.

Top module: `cache_rate_mon`

## Requirements
- R1: While running, each rising clock edge with `ev_hit`, `ev_miss` or `ev_hit_ws` high adds one to the hit counter (address 2), the miss counter (address 3) or the one-wait-state hit counter (address 4). Simultaneous events each count in their own counter.
- R2: After reset the monitor is frozen and all registers read zero. Control register (address 0) bit 0 = 1 starts counting and 0 freezes it. While frozen, the counters and the interval timer hold their values and events are ignored.
- R3: A counter at all-ones stays at all-ones on further events and does not wrap.
- R4: A register write to a counter address loads that counter with the write data. If an event for that counter arrives in the same cycle, the written value wins.
- R5: Status bit 0 (miss flag) is set on the edge where an event raises the miss counter to equal the nonzero miss limit (address 6). A limit of zero never sets it.
- R6: Status bit 1 (hit flag) is set on the edge where an event raises the hit counter to equal the nonzero hit limit (address 5). A limit of zero never sets it.
- R7: With a nonzero interval N (address 7, 19 bits, upper write bits dropped), status bit 2 is set after every N running cycles, and the timer reloads each time. Writing the interval restarts the timer. An interval of zero never sets the flag.
- R8: Status flags (address 1, bits [2:0]) stay set until a write to address 1 with a one in that bit position. A flag set in the same cycle as its clear stays set.
- R9: `irq` is high exactly when control bit 1 (interrupt enable) is 1 and at least one status flag is set.
- R10: Every register reads back through `reg_raddr`/`reg_rdata` combinationally. Unused upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_hit | input | 1 | One-cycle pulse per cache hit |
| ev_miss | input | 1 | One-cycle pulse per cache miss |
| ev_hit_ws | input | 1 | One-cycle pulse per hit with one wait state |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Register write address |
| reg_wdata | input | CNT_W | Register write data |
| reg_raddr | input | ADDR_W | Register read address |
| reg_rdata | output | CNT_W | Register read data |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach are the ones where two sources act on the same state in one cycle. One is a counter write that meets its own event. The other is a flag clear that meets the event that sets the same flag. Because the bench drives the register port and the event pins on the same falling edge, both actions land on one rising edge. Saturation is reached without billions of events by loading a counter to one below all-ones. The interval timer's reload is checked by counting falling edges from the interval write and looking at the flag one cycle before and on the expected cycle, twice in a row.

// File: rtl/cache_rate_mon.sv
module cache_rate_mon #(
  parameter int CNT_W  = 32,
  parameter int TMR_W  = 19,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_hit,
  input  logic              ev_miss,
  input  logic              ev_hit_ws,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [CNT_W-1:0]  reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HIT   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MISS  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_HWS   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_THIT  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_TMISS = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_IVL   = ADDR_W'(7);
  localparam logic [CNT_W-1:0]  CMAX    = {CNT_W{1'b1}};

  logic             run, irq_en;
  logic [2:0]       st;
  logic [CNT_W-1:0] hit_cnt, miss_cnt, hws_cnt, thr_hit, thr_miss;
  logic [TMR_W-1:0] ivl, tmr;

  logic wr_hit, wr_miss, wr_hws, wr_ivl;
  logic inc_hit, inc_miss, inc_hws;
  logic tmr_on, tmr_last;
  logic set_miss, set_hit, set_ivl;
  logic [2:0] clr;

  assign wr_hit  = reg_we && reg_waddr == A_HIT;
  assign wr_miss = reg_we && reg_waddr == A_MISS;
  assign wr_hws  = reg_we && reg_waddr == A_HWS;
  assign wr_ivl  = reg_we && reg_waddr == A_IVL;

  assign inc_hit  = run && ev_hit    && !wr_hit  && hit_cnt  != CMAX;
  assign inc_miss = run && ev_miss   && !wr_miss && miss_cnt != CMAX;
  assign inc_hws  = run && ev_hit_ws && !wr_hws  && hws_cnt  != CMAX;

  assign set_hit  = inc_hit  && thr_hit  != '0 && hit_cnt  + 1'b1 == thr_hit;
  assign set_miss = inc_miss && thr_miss != '0 && miss_cnt + 1'b1 == thr_miss;

  assign tmr_on   = run && ivl != '0 && !wr_ivl;
  assign tmr_last = tmr >= ivl - 1'b1;
  assign set_ivl  = tmr_on && tmr_last;

  assign clr = (reg_we && reg_waddr == A_STAT) ? reg_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      irq_en <= 1'b0;
    end else if (reg_we && reg_waddr == A_CTRL) begin
      run    <= reg_wdata[0];
      irq_en <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_hit  <= '0;
      thr_miss <= '0;
    end else if (reg_we) begin
      if (reg_waddr == A_THIT)  thr_hit  <= reg_wdata;
      if (reg_waddr == A_TMISS) thr_miss <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hit_cnt <= '0;
    else if (wr_hit)  hit_cnt <= reg_wdata;
    else if (inc_hit) hit_cnt <= hit_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        miss_cnt <= '0;
    else if (wr_miss)  miss_cnt <= reg_wdata;
    else if (inc_miss) miss_cnt <= miss_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hws_cnt <= '0;
    else if (wr_hws)  hws_cnt <= reg_wdata;
    else if (inc_hws) hws_cnt <= hws_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl <= '0;
      tmr <= '0;
    end else if (wr_ivl) begin
      ivl <= reg_wdata[TMR_W-1:0];
      tmr <= '0;
    end else if (tmr_on) begin
      tmr <= tmr_last ? '0 : tmr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= (st & ~clr) | {set_ivl, set_hit, set_miss};
  end

  assign irq = irq_en && (st != '0);

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      A_CTRL:  reg_rdata[1:0] = {irq_en, run};
      A_STAT:  reg_rdata[2:0] = st;
      A_HIT:   reg_rdata = hit_cnt;
      A_MISS:  reg_rdata = miss_cnt;
      A_HWS:   reg_rdata = hws_cnt;
      A_THIT:  reg_rdata = thr_hit;
      A_TMISS: reg_rdata = thr_miss;
      A_IVL:   reg_rdata[TMR_W-1:0] = ivl;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cache_rate_mon_chk.sv
module cache_rate_mon_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              irq_en,
  input logic [2:0]        st,
  input logic [CNT_W-1:0]  hit_cnt,
  input logic [CNT_W-1:0]  miss_cnt,
  input logic [CNT_W-1:0]  thr_hit,
  input logic [CNT_W-1:0]  thr_miss,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_waddr,
  input logic [CNT_W-1:0]  reg_wdata,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HIT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MISS = ADDR_W'(3);
  localparam logic [CNT_W-1:0]  CMAX   = {CNT_W{1'b1}};

  assert_hold_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !(reg_we && reg_waddr == A_HIT) |=> $stable(hit_cnt));

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cnt == CMAX && !(reg_we && reg_waddr == A_MISS) |=> miss_cnt == CMAX);

  assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_waddr == A_MISS |=> miss_cnt == $past(reg_wdata));

  assert_zero_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !st[0] && thr_miss == '0 |=> !st[0]);

  assert_zero_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !st[1] && thr_hit == '0 |=> !st[1]);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st[2] && !(reg_we && reg_waddr == A_STAT && reg_wdata[2]) |=> st[2]);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'b000 |-> !irq);
endmodule

bind cache_rate_mon cache_rate_mon_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .irq_en(irq_en), .st(st),
  .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .thr_hit(thr_hit), .thr_miss(thr_miss),
  .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .irq(irq)
);

// File: tb/cache_rate_mon_tb.sv
`timescale 1ns/1ps
module cache_rate_mon_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_hit = 1'b0, ev_miss = 1'b0, ev_hit_ws = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  cache_rate_mon u_dut (
    .clk(clk), .rst_n(rst_n), .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_hit_ws(ev_hit_ws),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input logic [2:0] a, input logic [31:0] mask, input logic [31:0] exp, input string tag);
    reg_raddr = a;
    #1;
    tests++;
    if ((reg_rdata & mask) !== exp) begin
      fails++;
      $display("FAIL %s: addr %0d got %h expected %h", tag, a, reg_rdata & mask, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1;
    tests++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input logic h, input logic m, input logic w);
    @(negedge clk);
    ev_hit = h; ev_miss = m; ev_hit_ws = w;
    @(negedge clk);
    ev_hit = 1'b0; ev_miss = 1'b0; ev_hit_ws = 1'b0;
  endtask

  task automatic wr_pulse(input logic [2:0] a, input logic [31:0] d, input logic h);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d; ev_hit = h;
    @(negedge clk);
    reg_we = 1'b0; ev_hit = 1'b0;
  endtask

  task automatic clear_counts();
    wr(3'd2, 0); wr(3'd3, 0); wr(3'd4, 0);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) chk(a[2:0], '1, 0, "R2 reset value");
    chk_irq(1'b0, "R9 reset irq");
  endtask

  task automatic t_count();
    wr(3'd0, 1);
    chk(3'd0, '1, 32'h1, "R10 control readback");
    repeat (3) pulse(1, 0, 0);
    repeat (2) pulse(0, 1, 0);
    pulse(0, 0, 1);
    pulse(1, 1, 0);
    chk(3'd2, '1, 4, "R1 hit count");
    chk(3'd3, '1, 3, "R1 miss count");
    chk(3'd4, '1, 1, "R1 wait-state hit count");
    clear_counts();
    chk(3'd2, '1, 0, "R4 clear by write");
  endtask

  task automatic t_freeze();
    wr(3'd0, 0);
    repeat (3) pulse(1, 1, 1);
    chk(3'd2, '1, 0, "R2 frozen hit");
    chk(3'd4, '1, 0, "R2 frozen wait-state hit");
    wr(3'd0, 1);
    pulse(1, 0, 0);
    chk(3'd2, '1, 1, "R2 resumed");
    clear_counts();
  endtask

  task automatic t_write_wins();
    wr_pulse(3'd2, 100, 1);
    chk(3'd2, '1, 100, "R4 write beats event");
    pulse(1, 0, 0);
    chk(3'd2, '1, 101, "R4 counts from written value");
    clear_counts();
  endtask

  task automatic t_saturate();
    wr(3'd2, 32'hFFFF_FFFE);
    pulse(1, 0, 0);
    chk(3'd2, '1, 32'hFFFF_FFFF, "R3 reach max");
    pulse(1, 0, 0);
    chk(3'd2, '1, 32'hFFFF_FFFF, "R3 no wrap");
    clear_counts();
  endtask

  task automatic t_miss_limit();
    wr(3'd6, 3);
    chk(3'd6, '1, 3, "R10 miss limit readback");
    repeat (2) pulse(0, 1, 0);
    chk(3'd1, '1, 0, "R5 below limit");
    pulse(0, 1, 0);
    chk(3'd1, '1, 1, "R5 limit reached");
    wr(3'd1, 1);
    repeat (2) pulse(0, 1, 0);
    chk(3'd1, '1, 0, "R5 not set again past limit");
    wr(3'd6, 0); wr(3'd3, 0);
    repeat (5) pulse(0, 1, 0);
    chk(3'd1, '1, 0, "R5 zero limit disables");
    clear_counts();
  endtask

  task automatic t_hit_limit();
    wr(3'd5, 2);
    pulse(1, 0, 0);
    chk(3'd1, '1, 0, "R6 below limit");
    pulse(1, 0, 0);
    chk(3'd1, '1, 2, "R6 limit reached");
    wr(3'd1, 2);
    wr(3'd5, 0); wr(3'd2, 0);
    repeat (4) pulse(1, 0, 0);
    chk(3'd1, '1, 0, "R6 zero limit disables");
    clear_counts();
  endtask

  task automatic t_interval();
    wr(3'd7, 5);
    repeat (4) @(negedge clk);
    chk(3'd1, 32'h4, 0, "R7 one cycle early");
    @(negedge clk);
    chk(3'd1, 32'h4, 4, "R7 interval elapsed");
    wr(3'd1, 4);
    repeat (2) @(negedge clk);
    chk(3'd1, 32'h4, 0, "R7 reload not yet");
    @(negedge clk);
    chk(3'd1, 32'h4, 4, "R7 reload elapsed");
    wr(3'd7, 32'hFFFF_FFFF);
    chk(3'd7, '1, 32'h7FFFF, "R10 interval width");
    wr(3'd7, 0); wr(3'd1, 7);
    repeat (20) @(negedge clk);
    chk(3'd1, '1, 0, "R7 zero interval disables");
  endtask

  task automatic t_irq_sticky();
    wr(3'd5, 1);
    pulse(1, 0, 0);
    chk_irq(1'b0, "R9 disabled irq");
    wr(3'd0, 3);
    chk_irq(1'b1, "R9 enabled irq");
    repeat (5) @(negedge clk);
    chk(3'd1, '1, 2, "R8 flag stays");
    wr(3'd1, 1);
    chk(3'd1, '1, 2, "R8 other bit clear ignored");
    wr(3'd1, 2);
    chk_irq(1'b0, "R9 irq drops after clear");
    wr(3'd2, 0);
    wr_pulse(3'd1, 2, 1);
    chk(3'd1, '1, 2, "R8 set beats clear");
    chk_irq(1'b1, "R9 irq after set");
    wr(3'd0, 1);
    chk_irq(1'b0, "R9 enable off");
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_freeze();
    t_write_wins();
    t_saturate();
    t_miss_limit();
    t_hit_limit();
    t_interval();
    t_irq_sticky();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule